// File: doc/BRIEF.md
# Two-to-One Lane Width Gearbox

This block connects a serializer-side parallel lane of `LANE_W` bits to a fabric bus of twice that width. The fabric side runs at half the rate of the serializer side. Both clocks come from one source and are edge-aligned, so the block runs entirely on the fast clock. A phase input, `phase_first`, is high during the fast cycle that opens each slow cycle. Every fabric-side signal is either sampled once per slow cycle or held steady for two fast cycles, so slow-clock logic can use it directly.

On transmit, a `2*LANE_W` fabric word is split into two lane words. The low half is sent first, and the earliest serial bit is always bit 0. On receive, two consecutive lane words are joined into one fabric word. The first word becomes the low half. The fabric word is released only after both halves have been captured in order.

A resynchronize request (`rx_flush`) clears the receive path. It discards any half word already held, drives zeros on the output and marks the output invalid until a fresh pair has arrived. Setting `BYPASS` builds an equal-width variant instead. In that variant each word passes through one register stage in each direction, with no reordering.

Top module: `lane_gearbox`

## Requirements
- R1: `LANE_W` must be one of 8, 10, 16, 20, 32 or 40. The fabric width is `2*LANE_W` when `BYPASS` is 0 and `LANE_W` when `BYPASS` is 1.
- R2: While reset is held, `tx_lane_data`, `rx_fab_data` and `rx_fab_valid` are all zero.
- R3: At a fast edge where `phase_first` is 1, the block samples `tx_fab_data`. Its bits `[LANE_W-1:0]` appear on `tx_lane_data` for the following fast cycle.
- R4: Bits `[2*LANE_W-1:LANE_W]` of that same sampled word appear on `tx_lane_data` for the fast cycle after that, whatever `tx_fab_data` holds by then.
- R5: The lane word sampled at a `phase_first`=1 edge becomes `rx_fab_data[LANE_W-1:0]`. The lane word sampled at the next edge (`phase_first`=0) becomes `rx_fab_data[2*LANE_W-1:LANE_W]`. Both appear, with `rx_fab_valid`=1, after that second edge.
- R6: Apart from a flush, `rx_fab_data` and `rx_fab_valid` do not change at an edge where `phase_first` is 1. They therefore hold each word for two fast cycles.
- R7: `rx_fab_valid` rises only after a first-half capture (`phase_first`=1) followed directly by a second-half capture (`phase_first`=0). A second-half word with no first half before it produces no output.
- R8: An edge with `rx_flush`=1 sets `rx_fab_data` to zero and `rx_fab_valid` to 0. It also discards any first half already captured.
- R9: With `BYPASS`=1, `tx_lane_data` equals the `tx_fab_data` sampled at the previous edge. `rx_fab_data` equals the previous edge's `rx_lane_data`, with `rx_fab_valid`=1 unless that edge flushed. `phase_first` has no effect.
- R10: `rx_flush` has no effect on the transmit path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serializer-side clock; the fabric clock is this divided by two, edge-aligned |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_first | input | 1 | High in the fast cycle that opens a slow cycle |
| tx_fab_data | input | FAB_W | Fabric word to transmit |
| tx_lane_data | output | LANE_W | Lane word to the serializer, bit 0 earliest |
| rx_lane_data | input | LANE_W | Lane word from the deserializer, bit 0 earliest |
| rx_flush | input | 1 | Resynchronize request: clear the receive path |
| rx_fab_data | output | FAB_W | Gathered fabric word |
| rx_fab_valid | output | 1 | `rx_fab_data` holds a complete pair |

## Verification
Every result sits one register stage behind the edge that samples its input, with these offsets:
- A transmit low half shows one fast cycle after the `phase_first` edge that sampled it.
- A transmit high half shows one cycle after that.
- A gathered receive word shows directly after its second-half edge.
- A flush clears the outputs directly after its own edge.

The bench drives inputs a quarter period after each rising edge and reads outputs at that same point after the next edge. It does this through one step task. Each comparison is therefore made against the inputs of exactly the previous edge, or the previous pair of edges. Expected words are computed arithmetically in the bench over a sweep of 2048 input pairs. A separate bypass instance is checked against the same edge timing.

// File: rtl/lgb_pkg.sv
package lgb_pkg;

  // Lane widths the serializer side accepts.
  function automatic bit lane_width_ok(input int w);
    return (w == 8) || (w == 10) || (w == 16) || (w == 20) || (w == 32) || (w == 40);
  endfunction

  function automatic int fab_width(input int lane_w, input bit bypass);
    return bypass ? lane_w : 2 * lane_w;
  endfunction

endpackage

// File: rtl/lgb_rst_sync.sv
module lgb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/lgb_tx_split.sv
module lgb_tx_split #(
  parameter int LANE_W = 10,
  parameter bit BYPASS = 1'b0,
  localparam int FAB_W = lgb_pkg::fab_width(LANE_W, BYPASS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_first,
  input  logic [FAB_W-1:0]  fab_data,
  output logic [LANE_W-1:0] lane_data
);

  logic [LANE_W-1:0] lane_d, lane_q;

  generate
    if (BYPASS) begin : g_pass
      always_comb lane_d = fab_data;

      a_r9_tx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lane_data == $past(fab_data));
    end else begin : g_split
      logic              hi_en;
      logic [LANE_W-1:0] hi_d, hi_q;

      // next-state: low half goes out at once, high half is parked
      always_comb begin
        hi_en  = phase_first;
        hi_d   = fab_data[FAB_W-1:LANE_W];
        lane_d = phase_first ? fab_data[LANE_W-1:0] : hi_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_en) hi_q <= hi_d;
      end

      a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        phase_first |=> lane_data == $past(fab_data[LANE_W-1:0]));
      a_r4_high_second: assert property (@(posedge clk) disable iff (!rst_n)
        phase_first ##1 !phase_first |=> lane_data == $past(fab_data[FAB_W-1:LANE_W], 2));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assign lane_data = lane_q;

endmodule

// File: rtl/lgb_rx_gather.sv
module lgb_rx_gather #(
  parameter int LANE_W = 10,
  parameter bit BYPASS = 1'b0,
  localparam int FAB_W = lgb_pkg::fab_width(LANE_W, BYPASS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_first,
  input  logic              flush,
  input  logic [LANE_W-1:0] lane_data,
  output logic [FAB_W-1:0]  fab_data,
  output logic              fab_valid
);

  logic             out_en;
  logic [FAB_W-1:0] out_d, out_q;
  logic             vld_d, vld_q;

  generate
    if (BYPASS) begin : g_pass
      always_comb begin
        out_en = 1'b1;
        out_d  = flush ? '0 : lane_data;
        vld_d  = !flush;
      end

      a_r9_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> fab_data == $past(lane_data) && fab_valid);
    end else begin : g_gather
      logic              lo_en, lo_ok_d, lo_ok_q;
      logic [LANE_W-1:0] lo_d, lo_q;

      // next-state: first half parks, second half completes the word
      always_comb begin
        lo_en   = flush | phase_first;
        lo_d    = flush ? '0 : lane_data;
        lo_ok_d = !flush && phase_first;
        out_en  = flush | (!phase_first && lo_ok_q);
        out_d   = flush ? '0 : {lane_data, lo_q};
        vld_d   = !flush;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q    <= '0;
          lo_ok_q <= 1'b0;
        end else begin
          if (lo_en) lo_q <= lo_d;
          lo_ok_q <= lo_ok_d;
        end
      end

      a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_first && !flush) ##1 (!phase_first && !flush) |=>
          fab_data == {$past(lane_data), $past(lane_data, 2)} && fab_valid);
      a_r6_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_first && !flush) |=> $stable(fab_data) && $stable(fab_valid));
      a_r7_valid_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fab_valid) |-> !$past(phase_first) && $past(phase_first, 2));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (out_en) begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign fab_data  = out_q;
  assign fab_valid = vld_q;

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fab_data == '0 && !fab_valid);

endmodule

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
  parameter int LANE_W = 10,
  parameter bit BYPASS = 1'b0,
  localparam int FAB_W = lgb_pkg::fab_width(LANE_W, BYPASS)
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              phase_first,
  input  logic [FAB_W-1:0]  tx_fab_data,
  output logic [LANE_W-1:0] tx_lane_data,
  input  logic [LANE_W-1:0] rx_lane_data,
  input  logic              rx_flush,
  output logic [FAB_W-1:0]  rx_fab_data,
  output logic              rx_fab_valid
);

  logic rst_q_n;

  initial begin
    a_r1_lane_width: assert (lgb_pkg::lane_width_ok(LANE_W))
      else $error("lane width %0d not supported", LANE_W);
  end

  lgb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lgb_tx_split #(.LANE_W(LANE_W), .BYPASS(BYPASS)) u_tx (
    .clk         (clk_fast),
    .rst_n       (rst_q_n),
    .phase_first (phase_first),
    .fab_data    (tx_fab_data),
    .lane_data   (tx_lane_data)
  );

  lgb_rx_gather #(.LANE_W(LANE_W), .BYPASS(BYPASS)) u_rx (
    .clk         (clk_fast),
    .rst_n       (rst_q_n),
    .phase_first (phase_first),
    .flush       (rx_flush),
    .lane_data   (rx_lane_data),
    .fab_data    (rx_fab_data),
    .fab_valid   (rx_fab_valid)
  );

  a_r2_reset_quiet: assert property (@(posedge clk_fast)
    !rst_n |=> tx_lane_data == '0 && rx_fab_data == '0 && !rx_fab_valid);

  a_r10_tx_ignores_flush: assert property (@(posedge clk_fast) disable iff (!rst_q_n)
    rx_flush && phase_first |=> tx_lane_data == $past(tx_fab_data[LANE_W-1:0]));

endmodule

// File: tb/lane_gearbox_bench.sv
module lane_gearbox_bench;

  localparam int PERIOD = 10;
  localparam int W      = 8;

  logic            clk_fast = 1'b0;
  logic            rst_n;
  logic            phase_first;
  logic [2*W-1:0]  tx_fab_data;
  logic [W-1:0]    tx_lane_data;
  logic [W-1:0]    rx_lane_data;
  logic            rx_flush;
  logic [2*W-1:0]  rx_fab_data;
  logic            rx_fab_valid;

  logic [W-1:0]    b_tx_fab, b_tx_lane, b_rx_lane, b_rx_fab;
  logic            b_flush, b_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk_fast = ~clk_fast;

  lane_gearbox #(.LANE_W(W), .BYPASS(1'b0)) u_lane_gearbox (
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .phase_first  (phase_first),
    .tx_fab_data  (tx_fab_data),
    .tx_lane_data (tx_lane_data),
    .rx_lane_data (rx_lane_data),
    .rx_flush     (rx_flush),
    .rx_fab_data  (rx_fab_data),
    .rx_fab_valid (rx_fab_valid)
  );

  lane_gearbox #(.LANE_W(W), .BYPASS(1'b1)) u_lane_gearbox_byp (
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .phase_first  (phase_first),
    .tx_fab_data  (b_tx_fab),
    .tx_lane_data (b_tx_lane),
    .rx_lane_data (b_rx_lane),
    .rx_flush     (b_flush),
    .rx_fab_data  (b_rx_fab),
    .rx_fab_valid (b_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one fast edge; results of that edge are readable on return
  task automatic step();
    @(posedge clk_fast);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb;
    pa = '0;
    pb = '0;
    rst_n = 1'b0; phase_first = 1'b0; tx_fab_data = '0; rx_lane_data = '0; rx_flush = 1'b0;
    b_tx_fab = 8'hA5; b_rx_lane = 8'h5A; b_flush = 1'b0;
    repeat (3) step();
    // R2: reset state on both variants
    chk("R2", tx_lane_data, 0);
    chk("R2", rx_fab_data, 0);
    chk("R2", rx_fab_valid, 0);
    chk("R2", b_tx_lane, 0);
    chk("R2", {b_rx_fab, b_valid}, 0);
    rst_n = 1'b1;
    b_tx_fab = '0; b_rx_lane = '0;
    repeat (3) step();
    rx_lane_data = 8'h99;
    step();
    // R7: second-half word alone after reset yields nothing
    chk("R7", rx_fab_valid, 0);
    chk("R7", rx_fab_data, 0);

    // sweep: transmit split, receive gather, bypass, in lockstep
    for (int i = 0; i < 2048; i++) begin
      logic [2*W-1:0] f;
      logic [W-1:0]   a, b;
      f = 16'(i * 40503 + 17);
      a = 8'(i * 13 + 1);
      b = 8'(i * 29 + 7);
      phase_first = 1'b1; tx_fab_data = f; rx_lane_data = a;
      b_tx_fab = f[W-1:0]; b_rx_lane = a;
      step();
      chk("R3", tx_lane_data, f[W-1:0]);
      if (i == 0) chk("R7", rx_fab_valid, 0);
      else begin
        chk("R6", rx_fab_data, {pb, pa});
        chk("R6", rx_fab_valid, 1);
      end
      chk("R9", b_tx_lane, f[W-1:0]);
      chk("R9", {b_rx_fab, b_valid}, {a, 1'b1});
      phase_first = 1'b0; tx_fab_data = ~f; rx_lane_data = b;
      b_tx_fab = f[2*W-1:W]; b_rx_lane = b;
      step();
      chk("R4", tx_lane_data, f[2*W-1:W]);
      chk("R5", rx_fab_data, {b, a});
      chk("R7", rx_fab_valid, 1);
      chk("R9", b_tx_lane, f[2*W-1:W]);
      chk("R9", {b_rx_fab, b_valid}, {b, 1'b1});
      pa = a;
      pb = b;
    end

    // flush on a second-half edge, after a first half was captured
    phase_first = 1'b1; tx_fab_data = 16'hBEEF; rx_lane_data = 8'hC3;
    step();
    chk("R6", rx_fab_valid, 1);
    phase_first = 1'b0; rx_flush = 1'b1; rx_lane_data = 8'h3C; b_flush = 1'b1; b_rx_lane = 8'h3C;
    step();
    chk("R8", rx_fab_data, 0);
    chk("R8", rx_fab_valid, 0);
    chk("R10", tx_lane_data, 8'hBE);
    chk("R9", {b_rx_fab, b_valid}, 0);
    rx_flush = 1'b0; b_flush = 1'b0; rx_lane_data = 8'h55; b_rx_lane = 8'h55;
    step();
    // R8: half captured before the flush is gone, so no word forms
    chk("R8", rx_fab_valid, 0);
    chk("R8", rx_fab_data, 0);
    chk("R9", {b_rx_fab, b_valid}, {8'h55, 1'b1});
    phase_first = 1'b1; rx_lane_data = 8'h11;
    step();
    chk("R7", rx_fab_valid, 0);
    phase_first = 1'b0; rx_lane_data = 8'h22;
    step();
    chk("R5", rx_fab_data, 16'h2211);
    chk("R7", rx_fab_valid, 1);

    // flush on a first-half edge: that half must not be kept
    phase_first = 1'b1; rx_flush = 1'b1; rx_lane_data = 8'h77; tx_fab_data = 16'h1234;
    step();
    chk("R8", rx_fab_data, 0);
    chk("R8", rx_fab_valid, 0);
    chk("R10", tx_lane_data, 8'h34);
    phase_first = 1'b0; rx_flush = 1'b0; rx_lane_data = 8'h88;
    step();
    chk("R10", tx_lane_data, 8'h12);
    chk("R8", rx_fab_valid, 0);
    chk("R8", rx_fab_data, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule